// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Register Bank

This block is the byte-wide register bank of an I2C master controller that holds the status, extended status, interrupt mask, mode control and extended control (soft reset) registers. It also drives the controller's single interrupt line. A host reaches the bank through a simple byte-addressed port over an 18-byte window. Reads are combinational from the address. Writes take effect at the next rising clock edge. Each register has its own write rule: a plain store, a masked store, or write-one-to-clear.

The transfer sequencer and the data buffer sit outside this block. They connect through per-bit set and clear strobes on status, and set strobes on extended status and extended control. They also connect through four event strobes that can raise the interrupt. The sequencer supplies a live bus-busy level, which the bank shows in extended status whenever that register is read.

The interrupt line is owned by a two-state machine. In `IRQ_QUIET` the line is low. A qualified event moves the machine to `IRQ_ASSERTED` (transition RAISE). A host acknowledge taken while interrupts are enabled returns it to `IRQ_QUIET` (transition ACK). A soft reset also returns it to `IRQ_QUIET` (transition FLUSH). Without any of these, the machine holds its state (transition HOLD). When RAISE and ACK arrive together, RAISE is taken.

Top module: `ic_stat_bank`

## Requirements
- R1: After reset, the following registers read 0x00 and the interrupt output is low: mode control (offset 7), status (offset 8), interrupt mask (offset 13) and extended control (offset 15). Extended status (offset 9) reads 0x40 when the bus is idle.
- R2: A host write to status clears only the stored bits that are set in (value AND 0x0A), which are bits 1 and 3. All other status bits are changed only by the sequencer strobes. A sequencer clear strobe clears its bit.
- R3: When a sequencer set strobe and a clear of the same status bit arrive in the same cycle, the bit ends set. The clear may come from the host or from the sequencer.
- R4: A host write to extended status clears the stored bits set in (value AND 0x8F). The sequencer set strobes set bits. On a read, bit 4 always equals the live bus-busy input, whatever value is stored there.
- R5: A write to mode control stores (value AND 0x3D), and the stored value appears on the mode output. Bit 3 (slave request) is stored but has no other effect. Bit 2 enables interrupts.
- R6: A write to extended control with bit 0 set performs a soft reset. The next cycle, mode control, status, interrupt mask and extended control read 0x00, extended status reads its reset value, the interrupt output is low, and the soft-reset output is high for exactly one cycle. A write with bit 0 clear only clears the stored bits set in (value AND 0xF0).
- R7: An event strobe raises the interrupt when mode control bit 2 is set and the matching interrupt mask bit is set. The mask bits are: bit 0 transfer complete, bit 1 target abort, bit 2 slave request, bit 3 halt done. When the interrupt is raised, the interrupt output is high the next cycle and status bit 1 is set.
- R8: The interrupt output falls only after one of two events. The first is a status write with bit 1 set while mode control bit 2 is set. The second is a soft reset. A status acknowledge written while bit 2 is clear still clears status bit 1, but the line stays high.
- R9: Every offset other than 7, 8, 9, 13 and 15 reads 0x00. This includes offsets 18 and above. Writes to those offsets change no register and no output.
- R10: The interrupt mask stores all eight written bits.
- R11: When a raise and an acknowledge arrive in the same cycle, the interrupt output stays high and status bit 1 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host byte offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr |
| bus_busy | input | 1 | Live bus-busy level from the bus logic |
| seq_set_sts | input | 8 | Per-bit set strobes for status |
| seq_clr_sts | input | 8 | Per-bit clear strobes for status |
| seq_set_xsts | input | 8 | Per-bit set strobes for extended status |
| seq_set_xctl | input | 8 | Per-bit set strobes for extended control |
| irq_evt | input | 4 | Event strobes: complete, abort, slave request, halt |
| mode_ctl_o | output | 8 | Stored mode control value |
| irq_o | output | 1 | Interrupt line |
| soft_rst_o | output | 1 | One-cycle pulse after a soft reset |

## Verification
The bench builds the bank with its default parameters: a 5-bit address and an 8-bit data path. With a 5-bit address the bench can reach offsets 18 through 31, so reads and writes beyond the 18-byte window are exercised alongside the unmapped offsets inside it. Random traffic uses sparse strobes, so set-versus-clear collisions, raise-versus-acknowledge collisions and soft resets in mid-activity occur among ordinary writes. These collisions are also forced by directed cases.

// File: rtl/ic_stat_pkg.sv
package ic_stat_pkg;
    localparam int unsigned REG_AW = 5;
    localparam int unsigned REG_DW = 8;
    localparam int unsigned WINDOW = 18;
    localparam int unsigned N_EVT  = 4;

    localparam logic [REG_AW-1:0] OFS_MODE = REG_AW'(7);
    localparam logic [REG_AW-1:0] OFS_STS  = REG_AW'(8);
    localparam logic [REG_AW-1:0] OFS_XSTS = REG_AW'(9);
    localparam logic [REG_AW-1:0] OFS_MASK = REG_AW'(13);
    localparam logic [REG_AW-1:0] OFS_XCTL = REG_AW'(15);

    localparam logic [REG_DW-1:0] STS_W1C   = 8'h0A;
    localparam logic [REG_DW-1:0] XSTS_W1C  = 8'h8F;
    localparam logic [REG_DW-1:0] XSTS_RST  = 8'h40;
    localparam logic [REG_DW-1:0] MODE_KEEP = 8'h3D;
    localparam logic [REG_DW-1:0] XCTL_W1C  = 8'hF0;

    localparam int unsigned BIT_IRQ_ACK = 1;
    localparam int unsigned BIT_IRQ_EN  = 2;
    localparam int unsigned BIT_SRST    = 0;
    localparam int unsigned BIT_BUSY    = 4;

    typedef enum logic [0:0] {
        IRQ_QUIET    = 1'b0,
        IRQ_ASSERTED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/ic_flag_reg.sv
module ic_flag_reg #(
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter logic [W-1:0] WR_MASK = '1,
    parameter bit           W1C     = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    output logic [W-1:0] q
);
    logic [W-1:0] after_wr;
    logic [W-1:0] nxt;

    generate
        if (W1C) begin : g_w1c
            assign after_wr = q & ~(wdata & WR_MASK);
        end else begin : g_store
            assign after_wr = wdata & WR_MASK;
        end
    endgenerate

    // hardware set is applied last so it wins over any clear
    always_comb begin
        nxt = wr_en ? after_wr : q;
        nxt = (nxt & ~hw_clr) | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= RST_VAL;
        else if (srst) q <= RST_VAL;
        else           q <= nxt;
    end
endmodule

// File: rtl/ic_irq_fsm.sv
module ic_irq_fsm
    import ic_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic raise,
    input  logic ack,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (!srst && raise) state_d = IRQ_ASSERTED;
            end
            IRQ_ASSERTED: begin
                if (srst)       state_d = IRQ_QUIET;
                else if (raise) state_d = IRQ_ASSERTED;
                else if (ack)   state_d = IRQ_QUIET;
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_ASSERTED);
    end
endmodule

// File: rtl/ic_read_mux.sv
module ic_read_mux
    import ic_stat_pkg::*;
(
    input  logic [REG_AW-1:0] addr,
    input  logic              bus_busy,
    input  logic [REG_DW-1:0] mode_q,
    input  logic [REG_DW-1:0] sts_q,
    input  logic [REG_DW-1:0] xsts_q,
    input  logic [REG_DW-1:0] mask_q,
    input  logic [REG_DW-1:0] xctl_q,
    output logic [REG_DW-1:0] rdata
);
    logic [REG_DW-1:0] xsts_view;

    always_comb begin
        xsts_view           = xsts_q;
        xsts_view[BIT_BUSY] = bus_busy;
    end

    always_comb begin
        rdata = '0;
        if (addr < REG_AW'(WINDOW)) begin
            unique case (addr)
                OFS_MODE: rdata = mode_q;
                OFS_STS:  rdata = sts_q;
                OFS_XSTS: rdata = xsts_view;
                OFS_MASK: rdata = mask_q;
                OFS_XCTL: rdata = xctl_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ic_stat_bank.sv
module ic_stat_bank
    import ic_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [REG_DW-1:0] host_wdata,
    output logic [REG_DW-1:0] host_rdata,
    input  logic              bus_busy,
    input  logic [REG_DW-1:0] seq_set_sts,
    input  logic [REG_DW-1:0] seq_clr_sts,
    input  logic [REG_DW-1:0] seq_set_xsts,
    input  logic [REG_DW-1:0] seq_set_xctl,
    input  logic [N_EVT-1:0]  irq_evt,
    output logic [REG_DW-1:0] mode_ctl_o,
    output logic              irq_o,
    output logic              soft_rst_o
);
    logic we_mode, we_sts, we_xsts, we_mask, we_xctl;
    logic srst, raise, ack, srst_q;
    logic [REG_DW-1:0] mode_q, sts_q, xsts_q, mask_q, xctl_q;
    logic [REG_DW-1:0] sts_set;

    always_comb begin
        we_mode = host_we && (host_addr == OFS_MODE);
        we_sts  = host_we && (host_addr == OFS_STS);
        we_xsts = host_we && (host_addr == OFS_XSTS);
        we_mask = host_we && (host_addr == OFS_MASK);
        we_xctl = host_we && (host_addr == OFS_XCTL);
        srst    = we_xctl && host_wdata[BIT_SRST];
    end

    always_comb begin
        raise = mode_q[BIT_IRQ_EN] && (|(irq_evt & mask_q[N_EVT-1:0]));
        ack   = we_sts && host_wdata[BIT_IRQ_ACK] && mode_q[BIT_IRQ_EN];
        sts_set = seq_set_sts;
        sts_set[BIT_IRQ_ACK] = seq_set_sts[BIT_IRQ_ACK] | raise;
    end

    ic_flag_reg #(.W(REG_DW), .RST_VAL('0), .WR_MASK(MODE_KEEP), .W1C(1'b0)) u_mode (
        .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(we_mode), .wdata(host_wdata),
        .hw_set('0), .hw_clr('0), .q(mode_q));

    ic_flag_reg #(.W(REG_DW), .RST_VAL('0), .WR_MASK(STS_W1C), .W1C(1'b1)) u_sts (
        .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(we_sts), .wdata(host_wdata),
        .hw_set(sts_set), .hw_clr(seq_clr_sts), .q(sts_q));

    ic_flag_reg #(.W(REG_DW), .RST_VAL(XSTS_RST), .WR_MASK(XSTS_W1C), .W1C(1'b1)) u_xsts (
        .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(we_xsts), .wdata(host_wdata),
        .hw_set(seq_set_xsts), .hw_clr('0), .q(xsts_q));

    ic_flag_reg #(.W(REG_DW), .RST_VAL('0), .WR_MASK('1), .W1C(1'b0)) u_mask (
        .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(we_mask), .wdata(host_wdata),
        .hw_set('0), .hw_clr('0), .q(mask_q));

    ic_flag_reg #(.W(REG_DW), .RST_VAL('0), .WR_MASK(XCTL_W1C), .W1C(1'b1)) u_xctl (
        .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(we_xctl), .wdata(host_wdata),
        .hw_set(seq_set_xctl), .hw_clr('0), .q(xctl_q));

    ic_irq_fsm u_irq (
        .clk(clk), .rst_n(rst_n), .srst(srst), .raise(raise), .ack(ack), .irq(irq_o));

    ic_read_mux u_rd (
        .addr(host_addr), .bus_busy(bus_busy), .mode_q(mode_q), .sts_q(sts_q),
        .xsts_q(xsts_q), .mask_q(mask_q), .xctl_q(xctl_q), .rdata(host_rdata));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= srst;
    end

    assign soft_rst_o = srst_q;
    assign mode_ctl_o = mode_q;
endmodule

// File: rtl/ic_stat_bank_chk.sv
module ic_stat_bank_chk
    import ic_stat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [REG_AW-1:0] host_addr,
    input logic [REG_DW-1:0] host_wdata,
    input logic [REG_DW-1:0] host_rdata,
    input logic              bus_busy,
    input logic [REG_DW-1:0] seq_set_sts,
    input logic [N_EVT-1:0]  irq_evt,
    input logic [REG_DW-1:0] mode_ctl_o,
    input logic              irq_o,
    input logic              soft_rst_o,
    input logic [REG_DW-1:0] sts_q,
    input logic [REG_DW-1:0] xsts_q,
    input logic [REG_DW-1:0] mask_q
);
    logic host_srst, host_ack, mapped;
    assign host_srst = host_we && host_addr == OFS_XCTL && host_wdata[BIT_SRST];
    assign host_ack  = host_we && host_addr == OFS_STS && host_wdata[BIT_IRQ_ACK]
                       && mode_ctl_o[BIT_IRQ_EN];
    assign mapped = host_addr == OFS_MODE || host_addr == OFS_STS || host_addr == OFS_XSTS
                    || host_addr == OFS_MASK || host_addr == OFS_XCTL;

    // R3
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|seq_set_sts) && !host_srst |=> (sts_q & $past(seq_set_sts)) == $past(seq_set_sts));
    // R4
    p_busy_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr == OFS_XSTS |-> host_rdata[BIT_BUSY] == bus_busy);
    // R5
    p_mode_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ctl_o & ~MODE_KEEP) == '0);
    // R6
    p_soft_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_srst |=> soft_rst_o && sts_q == '0 && xsts_q == XSTS_RST && !irq_o);
    // R7
    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ctl_o[BIT_IRQ_EN] && (|(irq_evt & mask_q[N_EVT-1:0])) && !host_srst
        |=> irq_o && sts_q[BIT_IRQ_ACK]);
    // R8
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !host_ack && !host_srst |=> irq_o);
    // R9
    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> host_rdata == '0);
endmodule

bind ic_stat_bank ic_stat_bank_chk i_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_busy(bus_busy),
    .seq_set_sts(seq_set_sts), .irq_evt(irq_evt), .mode_ctl_o(mode_ctl_o),
    .irq_o(irq_o), .soft_rst_o(soft_rst_o), .sts_q(sts_q), .xsts_q(xsts_q),
    .mask_q(mask_q));

// File: tb/test_ic_stat_bank.sv
`timescale 1ns/100ps
module test_ic_stat_bank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       bus_busy = 1'b0;
    logic [7:0] seq_set_sts = '0, seq_clr_sts = '0, seq_set_xsts = '0, seq_set_xctl = '0;
    logic [3:0] irq_evt = '0;
    logic [7:0] mode_ctl_o;
    logic       irq_o, soft_rst_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model, built from the requirements
    logic [7:0] m_sts, m_xsts, m_mode, m_mask, m_xctl;
    logic m_irq, m_srp;

    always #4 clk = ~clk;

    ic_stat_bank i_ic_stat_bank (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_busy(bus_busy),
        .seq_set_sts(seq_set_sts), .seq_clr_sts(seq_clr_sts), .seq_set_xsts(seq_set_xsts),
        .seq_set_xctl(seq_set_xctl), .irq_evt(irq_evt), .mode_ctl_o(mode_ctl_o),
        .irq_o(irq_o), .soft_rst_o(soft_rst_o));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [4:0] a);
        case (a)
            5'd7:  return m_mode;
            5'd8:  return m_sts;
            5'd9:  return {m_xsts[7:5], bus_busy, m_xsts[3:0]};
            5'd13: return m_mask;
            5'd15: return m_xctl;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_sts = 0; m_xsts = 8'h40; m_mode = 0; m_mask = 0; m_xctl = 0; m_irq = 0; m_srp = 0;
    endtask

    // one clock of stimulus; model advanced, outputs compared after the edge
    task automatic cyc(input logic we, input logic [4:0] a, input logic [7:0] d,
                       input logic [7:0] ss, input logic [7:0] sc, input logic [7:0] xs,
                       input logic [7:0] cs, input logic [3:0] ev, input string tag);
        logic raise, ack;
        @(negedge clk);
        host_we = we; host_addr = a; host_wdata = d;
        seq_set_sts = ss; seq_clr_sts = sc; seq_set_xsts = xs; seq_set_xctl = cs; irq_evt = ev;
        if (we && a == 5'd15 && d[0]) begin
            model_reset();
            m_srp = 1;
        end else begin
            raise = m_mode[2] && (|(ev & m_mask[3:0]));
            ack = we && a == 5'd8 && d[1] && m_mode[2];
            if (we && a == 5'd8) m_sts = m_sts & ~(d & 8'h0A);
            m_sts = (m_sts & ~sc) | ss | (raise ? 8'h02 : 8'h00);
            if (we && a == 5'd9) m_xsts = m_xsts & ~(d & 8'h8F);
            m_xsts = m_xsts | xs;
            if (we && a == 5'd15) m_xctl = m_xctl & ~(d & 8'hF0);
            m_xctl = m_xctl | cs;
            if (we && a == 5'd7) m_mode = d & 8'h3D;
            if (we && a == 5'd13) m_mask = d;
            if (raise) m_irq = 1; else if (ack) m_irq = 0;
            m_srp = 0;
        end
        @(posedge clk);
        #1;
        chk({tag, " irq"}, {7'd0, irq_o}, {7'd0, m_irq});
        chk({tag, " soft_rst"}, {7'd0, soft_rst_o}, {7'd0, m_srp});
        chk({tag, " mode"}, mode_ctl_o, m_mode);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, a, d, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic read_all(input string tag);
        @(negedge clk);
        host_we = 0; seq_set_sts = 0; seq_clr_sts = 0; seq_set_xsts = 0; seq_set_xctl = 0; irq_evt = 0;
        for (int a = 0; a < 24; a++) begin
            host_addr = 5'(a);
            #0.1;
            chk($sformatf("%s rd[%0d]", tag, a), host_rdata, exp_read(5'(a)));
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [4:0] ra;
        logic [7:0] rd;
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        rst_n = 1;
        read_all("R1 reset");
        chk("R1 irq reset", {7'd0, irq_o}, 8'd0);

        // R10 mask, R5 mode
        wr(5'd13, 8'hA5, "R10");
        wr(5'd7, 8'hFF, "R5");
        read_all("R5 R10");
        wr(5'd7, 8'h08, "R5 slave bit");
        read_all("R5 slave");

        // R2 status clear rule
        cyc(0, 0, 0, 8'h3F, 0, 0, 0, 0, "R2 seed");
        wr(5'd8, 8'hFF, "R2 w1c");
        read_all("R2");
        cyc(0, 0, 0, 0, 8'h20, 0, 0, 0, "R2 seq clr");
        read_all("R2 seq clr");

        // R3 set beats host clear
        cyc(1, 5'd8, 8'h08, 8'h08, 0, 0, 0, 0, "R3 host");
        cyc(0, 0, 0, 8'h04, 8'h04, 0, 0, 0, "R3 seq");
        read_all("R3");

        // R4 extended status and busy view
        cyc(0, 0, 0, 0, 0, 8'h9F, 0, 0, "R4 seed");
        bus_busy = 1; read_all("R4 busy1");
        wr(5'd9, 8'hFF, "R4 w1c");
        bus_busy = 0; read_all("R4 busy0");

        // R7, R8, R11 interrupt
        wr(5'd7, 8'h04, "R7 en");
        wr(5'd13, 8'h08, "R7 mask");
        cyc(0, 0, 0, 0, 0, 0, 0, 4'h7, "R7 unmasked");
        cyc(0, 0, 0, 0, 0, 0, 0, 4'h8, "R7 halt");
        read_all("R7");
        wr(5'd7, 8'h00, "R8 dis");
        wr(5'd8, 8'h02, "R8 ack disabled");
        read_all("R8 held");
        wr(5'd7, 8'h04, "R8 en");
        cyc(1, 5'd8, 8'h02, 0, 0, 0, 0, 4'h8, "R11 collide");
        read_all("R11");
        wr(5'd8, 8'h02, "R8 ack");
        read_all("R8 low");

        // R9 unmapped and out-of-window writes
        wr(5'd12, 8'hFF, "R9 ofs12");
        wr(5'd20, 8'hFF, "R9 ofs20");
        wr(5'd31, 8'h01, "R9 ofs31");
        read_all("R9");

        // R6 soft reset and xctl clear rule
        cyc(0, 0, 0, 8'h21, 0, 8'h0C, 8'hF6, 0, "R6 seed");
        wr(5'd15, 8'h30, "R6 w1c");
        read_all("R6 w1c");
        wr(5'd15, 8'h01, "R6 srst");
        read_all("R6 after");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R6 pulse end");

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            case ($urandom_range(0, 5))
                0: ra = 5'd7; 1: ra = 5'd8; 2: ra = 5'd9; 3: ra = 5'd13;
                4: ra = 5'd15; default: ra = 5'($urandom);
            endcase
            rd = 8'($urandom);
            if (ra == 5'd15 && $urandom_range(0, 9) != 0) rd[0] = 1'b0;
            bus_busy = 1'($urandom);
            cyc(1'($urandom), ra, rd, 8'($urandom & $urandom & $urandom),
                8'($urandom & $urandom & $urandom), 8'($urandom & $urandom & $urandom),
                8'($urandom & $urandom & $urandom), 4'($urandom & $urandom), "R2 R3 R7 random");
            if (i % 50 == 0) read_all("R4 R9 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule